// File: doc/BRIEF.md
# Request-Acknowledge-Write Sequence Monitor

This block is a synthesizable runtime monitor that sits beside a bus agent and watches five single-bit control lines on every rising clock edge: a request line, an acknowledge line, a write line, a hold line and a completion line. It looks for a trigger pattern: one or more consecutive request cycles, then a single acknowledge cycle, then a fixed run of consecutive write cycles (four by default). Once that pattern completes, the monitor checks the cycles that follow. It accepts any number of cycles in which hold is high and request is low, and the check ends at the first cycle in which completion is high.

The verdict comes out as one of two registered, one-cycle pulses. `pass_o` means a response completed correctly. `fail_o` means a response cycle broke the rule. A trigger attempt that breaks before it completes is dropped without any pulse. While a response is pending, the monitor does not look for a new trigger. All inputs are plain level signals sampled at the clock edge. The block has no data path and no handshake of its own.

Top module: `sqmon_top`

## Requirements
- R1: The trigger is one or more cycles with `req_i` high, then one cycle with `ack_i` high, then `WR_BEATS` consecutive cycles with `wr_i` high. The response check starts on the cycle after the last write cycle. A `done_i` seen during any trigger cycle has no effect.
- R2: If the first response cycle has `done_i` high, `pass_o` is high for the single cycle after that clock edge.
- R3: Response cycles with `hold_i` high and `req_i` low may come in any number before the `done_i` cycle. `pass_o` then pulses after the edge at which `done_i` is sampled.
- R4: A response cycle with `done_i` low and without (`hold_i` high and `req_i` low) makes `fail_o` high for the single cycle after that edge, and the monitor returns to idle.
- R5: In a response cycle, a high `done_i` gives a pass whatever the values of `hold_i` and `req_i` are.
- R6: A trigger that breaks before it completes (no acknowledge after the request run, a second acknowledge, or fewer write cycles than `WR_BEATS`) is dropped with no pulse. If `req_i` is high in the cycle that breaks it, that cycle starts a new request run.
- R7: During the request run, a cycle with `ack_i` high ends the run even when `req_i` is also high in that cycle.
- R8: From the cycle after trigger completion up to and including the cycle that resolves the response, `req_i`, `ack_i` and `wr_i` cannot start a new trigger. The next trigger can start only on the cycle after the resolving cycle.
- R9: While `rst_n` is low at a clock edge, both pulses are low after that edge and the monitor returns to idle, dropping any pending response.
- R10: `pass_o` and `fail_o` are never high together, and neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Request line being monitored |
| ack_i | input | 1 | Acknowledge line being monitored |
| wr_i | input | 1 | Write line being monitored |
| hold_i | input | 1 | Hold line allowed in the response phase |
| done_i | input | 1 | Completion line that ends the response phase |
| pass_o | output | 1 | One-cycle pulse: response completed correctly |
| fail_o | output | 1 | One-cycle pulse: response rule broken |

## Verification
Suppose the trigger matcher is left in a wrong state, for example a wrong write count or a lost request run. Then the response check starts one cycle too early or too late, or does not start at all. A hold-free response shows this at the ports within one cycle as a missing or extra pulse. A stuck busy flag shows up within one cycle of the next response cycle as a missing verdict, or as a verdict when the monitor is idle. A response flag that stays stuck after a verdict shows up as a second pulse in the very next cycle. The sweeps place an idle cycle after every case, so that cycle catches it.

// File: rtl/sqmon_pkg.sv
package sqmon_pkg;

  // Trigger matcher phases
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_REQ  = 2'd1,
    TS_ACK  = 2'd2,
    TS_BEAT = 2'd3
  } trig_state_e;

  // Per-cycle verdict of the response checker
  typedef enum logic [1:0] {
    RV_NONE = 2'd0,
    RV_PASS = 2'd1,
    RV_FAIL = 2'd2
  } verdict_e;

endpackage

// File: rtl/sqmon_trigger.sv
module sqmon_trigger
  import sqmon_pkg::*;
#(
  parameter int WR_BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic req_i,
  input  logic ack_i,
  input  logic wr_i,
  output logic fire
);

  localparam int CW = (WR_BEATS < 2) ? 1 : $clog2(WR_BEATS + 1);
  localparam logic [CW-1:0] LAST_BEAT = CW'(WR_BEATS - 1);

  trig_state_e     state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fire    = 1'b0;
    if (!enable) begin
      state_d = TS_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        TS_IDLE: begin
          if (req_i) state_d = TS_REQ;
        end
        TS_REQ: begin
          // acknowledge closes the request run, even with req still high
          if (ack_i)      state_d = TS_ACK;
          else if (req_i) state_d = TS_REQ;
          else            state_d = TS_IDLE;
        end
        TS_ACK: begin
          if (wr_i) begin
            if (WR_BEATS == 1) begin
              fire    = 1'b1;
              state_d = TS_IDLE;
              cnt_d   = '0;
            end else begin
              state_d = TS_BEAT;
              cnt_d   = CW'(1);
            end
          end else begin
            state_d = req_i ? TS_REQ : TS_IDLE;
            cnt_d   = '0;
          end
        end
        TS_BEAT: begin
          if (wr_i) begin
            if (cnt_q == LAST_BEAT) begin
              fire    = 1'b1;
              state_d = TS_IDLE;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end else begin
            state_d = req_i ? TS_REQ : TS_IDLE;
            cnt_d   = '0;
          end
        end
        default: begin
          state_d = TS_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sqmon_response.sv
module sqmon_response
  import sqmon_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     req_i,
  input  logic     hold_i,
  input  logic     done_i,
  output logic     busy,
  output verdict_e verdict
);

  logic busy_d;

  always_comb begin
    verdict = RV_NONE;
    if (busy) begin
      if (done_i)               verdict = RV_PASS;
      else if (hold_i && !req_i) verdict = RV_NONE;
      else                      verdict = RV_FAIL;
    end
    busy_d = start | (busy & (verdict == RV_NONE));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= busy_d;
  end

endmodule

// File: rtl/sqmon_pulse.sv
module sqmon_pulse
  import sqmon_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  verdict_e verdict,
  output logic     pass_o,
  output logic     fail_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      pass_o <= (verdict == RV_PASS);
      fail_o <= (verdict == RV_FAIL);
    end
  end

endmodule

// File: rtl/sqmon_top.sv
module sqmon_top
  import sqmon_pkg::*;
#(
  parameter int WR_BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic ack_i,
  input  logic wr_i,
  input  logic hold_i,
  input  logic done_i,
  output logic pass_o,
  output logic fail_o
);

  logic     trig_fire;
  logic     resp_busy;
  verdict_e resp_verdict;

  // trigger search is suspended while a response is pending
  sqmon_trigger #(.WR_BEATS(WR_BEATS)) u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (!resp_busy),
    .req_i  (req_i),
    .ack_i  (ack_i),
    .wr_i   (wr_i),
    .fire   (trig_fire)
  );

  sqmon_response u_resp (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (trig_fire),
    .req_i   (req_i),
    .hold_i  (hold_i),
    .done_i  (done_i),
    .busy    (resp_busy),
    .verdict (resp_verdict)
  );

  sqmon_pulse u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .verdict (resp_verdict),
    .pass_o  (pass_o),
    .fail_o  (fail_o)
  );

endmodule

// File: rtl/sqmon_chk.sv
module sqmon_chk (
  input logic clk,
  input logic rst_n,
  input logic req_i,
  input logic wr_i,
  input logic hold_i,
  input logic done_i,
  input logic pass_o,
  input logic fail_o,
  input logic busy
);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));

  p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_o || fail_o) |=> !(pass_o || fail_o));

  p_pass_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> $past(done_i));

  p_fail_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> $past(!done_i && !(hold_i && !req_i)));

  p_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_i));

  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |=> (!pass_o && !fail_o && !busy));

endmodule

bind sqmon_top sqmon_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req_i  (req_i),
  .wr_i   (wr_i),
  .hold_i (hold_i),
  .done_i (done_i),
  .pass_o (pass_o),
  .fail_o (fail_o),
  .busy   (resp_busy)
);

// File: tb/tb_sqmon_top.sv
`timescale 1ns/1ps
module tb_sqmon_top;

  localparam int WB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, ack = 1'b0, wr = 1'b0, hold = 1'b0, done = 1'b0;
  logic pass_o, fail_o;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  sqmon_top #(.WR_BEATS(WB)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ack_i(ack), .wr_i(wr),
    .hold_i(hold), .done_i(done), .pass_o(pass_o), .fail_o(fail_o)
  );

  // one cycle: drive at negedge, check the registered pulses just after the edge
  task automatic step(input logic r, a, w, h, d, rn,
                      input logic ep, ef, input string tag);
    @(negedge clk);
    req = r; ack = a; wr = w; hold = h; done = d; rst_n = rn;
    @(posedge clk); #1;
    checks++;
    if (pass_o !== ep || fail_o !== ef) begin
      failures++;
      $display("FAIL %s: pass=%b fail=%b expected pass=%b fail=%b",
               tag, pass_o, fail_o, ep, ef);
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 1, 0, 0, tag);
  endtask

  task automatic trig(input int nreq, input string tag);
    for (int i = 0; i < nreq; i++) step(1, 0, 0, 0, 0, 1, 0, 0, tag);
    step(0, 1, 0, 0, 0, 1, 0, 0, tag);
    for (int i = 0; i < WB; i++) step(0, 0, 1, 0, 0, 1, 0, 0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R9: reset state
    step(1, 1, 1, 1, 1, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
    idle("R9");

    // Sweep: request run length x hold count x ending kind
    for (int nr = 1; nr <= 3; nr++) begin
      for (int nh = 0; nh <= 4; nh++) begin
        for (int e = 0; e < 3; e++) begin
          trig(nr, "R1");
          for (int k = 0; k < nh; k++) step(0, 0, 0, 1, 0, 1, 0, 0, "R3");
          if (e == 0)      step(0, 0, 0, 0, 1, 1, 1, 0, (nh == 0) ? "R2" : "R3");
          else if (e == 1) step(0, 0, 0, 0, 0, 1, 0, 1, "R4");
          else             step(1, 0, 0, 1, 0, 1, 0, 1, "R4");
          idle("R10");
        end
      end
    end

    // R1: done during the final write cycle is not a response (non-overlapping)
    step(1, 0, 0, 0, 0, 1, 0, 0, "R1");
    step(0, 1, 0, 0, 0, 1, 0, 0, "R1");
    for (int i = 0; i < WB - 1; i++) step(0, 0, 1, 0, 0, 1, 0, 0, "R1");
    step(0, 0, 1, 0, 1, 1, 0, 0, "R1");
    step(0, 0, 0, 0, 1, 1, 1, 0, "R1");
    idle("R10");

    // R5: done wins with req high and hold low
    trig(1, "R5");
    step(1, 0, 0, 0, 1, 1, 1, 0, "R5");
    idle("R5");

    // R7: ack together with req closes the request run
    step(1, 0, 0, 0, 0, 1, 0, 0, "R7");
    step(1, 1, 0, 0, 0, 1, 0, 0, "R7");
    for (int i = 0; i < WB; i++) step(0, 0, 1, 0, 0, 1, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 1, 1, 0, "R7");

    // R6: missing ack, double ack, short write run -> no check afterwards
    step(1, 0, 0, 0, 0, 1, 0, 0, "R6");
    step(0, 0, 1, 0, 0, 1, 0, 0, "R6");
    for (int i = 0; i < WB; i++) step(0, 0, 1, 0, 0, 1, 0, 0, "R6");
    idle("R6");
    step(1, 0, 0, 0, 0, 1, 0, 0, "R6");
    step(0, 1, 0, 0, 0, 1, 0, 0, "R6");
    step(0, 1, 0, 0, 0, 1, 0, 0, "R6");
    for (int i = 0; i < WB; i++) step(0, 0, 1, 0, 0, 1, 0, 0, "R6");
    idle("R6");
    step(1, 0, 0, 0, 0, 1, 0, 0, "R6");
    step(0, 1, 0, 0, 0, 1, 0, 0, "R6");
    for (int i = 0; i < WB - 1; i++) step(0, 0, 1, 0, 0, 1, 0, 0, "R6");
    idle("R6");
    idle("R6");
    // R6: req in the breaking cycle restarts the request run
    step(1, 0, 0, 0, 0, 1, 0, 0, "R6");
    step(0, 1, 0, 0, 0, 1, 0, 0, "R6");
    for (int i = 0; i < WB - 1; i++) step(0, 0, 1, 0, 0, 1, 0, 0, "R6");
    step(1, 0, 0, 0, 0, 1, 0, 0, "R6");
    step(0, 1, 0, 0, 0, 1, 0, 0, "R6");
    for (int i = 0; i < WB; i++) step(0, 0, 1, 0, 0, 1, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 1, 1, 0, "R6");

    // R8: trigger activity during response and in the resolving cycle is ignored
    trig(1, "R8");
    step(0, 1, 1, 1, 0, 1, 0, 0, "R8");
    for (int i = 0; i < WB; i++) step(0, 0, 1, 1, 0, 1, 0, 0, "R8");
    step(1, 0, 0, 0, 1, 1, 1, 0, "R8");
    step(0, 1, 0, 0, 0, 1, 0, 0, "R8");
    for (int i = 0; i < WB; i++) step(0, 0, 1, 0, 0, 1, 0, 0, "R8");
    idle("R8");

    // R9: reset drops a pending response
    trig(2, "R9");
    step(0, 0, 0, 1, 0, 1, 0, 0, "R9");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R9");
    idle("R9");
    step(0, 0, 0, 0, 1, 1, 0, 0, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule